// File: doc/BRIEF.md
# Bytecode Opcode Prefetch Buffer

This block sits between the memory port and the microcode sequencer of a bytecode interpreter. It keeps a window of up to eight upcoming instruction bytes, taken from one 64-bit memory word. When the window runs dry it fetches the next aligned word by itself, with no help from the sequencer. On every accepted dispatch the block hands out the oldest unread byte. It also drives a 12-bit microcode address, so that the sequencer can make a 256-way branch on that byte inside a table chosen by a 4-bit base.

A taken jump loads a new byte address. The block drops whatever it holds and fetches the aligned word that contains the new address. It starts reading that word at the byte lane that matches the low three address bits. If a fetch is still in flight when the jump arrives, the block waits for the late data, throws it away and only then asks for the new word. This keeps one request at most outstanding on the memory port.

The controller is a four-state machine:
- ST_ISSUE drives a one-cycle read request.
- ST_WAIT waits for the read data.
- ST_READY serves bytes to the sequencer.
- ST_DRAIN swallows a response that a jump has made stale.

Its transitions are:
- ISSUE to WAIT when the request goes out.
- ISSUE to ISSUE when a jump arrives in that cycle, which suppresses the request.
- WAIT to READY when data arrives.
- WAIT to DRAIN on a jump while data is still pending.
- WAIT to ISSUE on a jump in the same cycle as the data.
- READY to ISSUE when the last lane is consumed, or on a jump.
- DRAIN to ISSUE when the stale data arrives.

Top module: `bytecode_prefetch`

## Requirements
- R1: While reset is asserted and after it, disp_valid stays low until the first word has returned. The first read after reset is to byte address 0.
- R2: Every read request is a single-cycle pulse with mem_addr[2:0] = 0. No new request is raised while an earlier one is still awaiting mem_rvalid.
- R3: Within a fetched word, the byte at address a sits in mem_rdata bits [8*(a mod 8)+7 : 8*(a mod 8)]. Bytes are presented in ascending address order.
- R4: A cycle with disp_req and disp_valid both high consumes the presented byte. From the next cycle the following byte is presented, or the buffer goes empty if it was the last lane.
- R5: disp_target equals {tbl_base, disp_byte}, with tbl_base in bits 11:8 and the byte in bits 7:0.
- R6: After the byte in lane 7 is consumed, the block requests the next word at the previous address plus 8 without any dispatch request. A dispatch made after that data has arrived is served at once.
- R7: While the buffer is empty, disp_valid is low and dispatch requests stall. They are served only once the refill data has arrived.
- R8: A pc_load discards every buffered byte. The next read is at the aligned word holding pc_value, and the first byte presented is the one at pc_value, skipping the lower lanes.
- R9: pc_load takes priority over disp_req. In a pc_load cycle disp_valid is low and no byte is consumed.
- R10: A pc_load while a read is outstanding causes that read's data to be discarded. The new read is issued only after that data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_load | input | 1 | Load a new byte address (taken jump) |
| pc_value | input | 16 | New byte address |
| tbl_base | input | 4 | Dispatch table base, upper bits of the target |
| disp_req | input | 1 | Sequencer requests the next byte |
| disp_valid | output | 1 | A byte is presented and may be consumed |
| disp_byte | output | 8 | Byte presented to the sequencer |
| disp_target | output | 12 | Microcode branch address for the presented byte |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 16 | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, lowest address in bits 7:0 |

## Verification
disp_byte, disp_target and disp_valid depend on the registered head lane and the state, so they are valid in the cycle in which disp_req is raised. The bench drives requests just after a falling edge and samples these outputs a nanosecond later, before the rising edge that consumes the byte. A refill becomes visible on the cycle after the rising edge that samples mem_rvalid. The bench therefore counts stall cycles against the model memory's fixed latency, expecting at least that many after a lane-7 consumption and none once an idle wait has covered the refill. Request addresses are logged at rising edges, and they are compared only after the request cycle has passed.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_DRAIN = 2'd3
    } pf_state_t;
endpackage

// File: rtl/bpf_fetch_ctl.sv
module bpf_fetch_ctl
    import bpf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 8,
    localparam int LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_value,
    input  logic              mem_rvalid,
    input  logic              take,
    input  logic              last,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill,
    output logic [LW-1:0]     fill_skip,
    output logic              disp_valid
);
    localparam int WA_W = ADDR_W - LW;

    pf_state_t       state, state_nx;
    logic [WA_W-1:0] waddr;
    logic [LW-1:0]   skip;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ISSUE: state_nx = pc_load ? ST_ISSUE : ST_WAIT;
            ST_WAIT: begin
                if (pc_load)         state_nx = mem_rvalid ? ST_ISSUE : ST_DRAIN;
                else if (mem_rvalid) state_nx = ST_READY;
            end
            ST_READY: begin
                if (pc_load || (take && last)) state_nx = ST_ISSUE;
            end
            ST_DRAIN: begin
                if (mem_rvalid) state_nx = ST_ISSUE;
            end
            default: state_nx = ST_ISSUE;
        endcase
    end

    // state register and address bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ISSUE;
            waddr <= '0;
            skip  <= '0;
        end else begin
            state <= state_nx;
            if (pc_load) begin
                waddr <= pc_value[ADDR_W-1:LW];
                skip  <= pc_value[LW-1:0];
            end else begin
                if (fill)
                    skip <= '0;
                if (state == ST_READY && take && last)
                    waddr <= waddr + WA_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state == ST_ISSUE) && !pc_load;
        mem_addr   = {waddr, {LW{1'b0}}};
        fill       = (state == ST_WAIT) && mem_rvalid && !pc_load;
        fill_skip  = skip;
        disp_valid = (state == ST_READY) && !pc_load;
    end

    // R2: a request pulse is never followed directly by another
    a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R6: draining lane 7 starts the next word fetch at +8
    a_r6_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last) |=> (state == ST_ISSUE && mem_addr == $past(mem_addr) + ADDR_W'(LANES)));

    // R10: no request while a stale response is still due
    a_r10_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !mem_req);

    // R8: a load retargets the fetch to the word holding the new address
    a_r8_load_retarget: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> ((state == ST_ISSUE || state == ST_DRAIN) &&
                     mem_addr[ADDR_W-1:LW] == $past(pc_value[ADDR_W-1:LW])));
endmodule

// File: rtl/bpf_byte_store.sv
module bpf_byte_store
    import bpf_pkg::*;
#(
    parameter int LANES   = 8,
    localparam int LW     = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [LW-1:0]     fill_skip,
    input  logic              take,
    output logic [BYTE_W-1:0] head_byte,
    output logic              last
);
    logic [DATA_W-1:0] word_q;
    logic [LW-1:0]     head;
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            head   <= '0;
        end else if (fill) begin
            word_q <= fill_data;
            head   <= fill_skip;
        end else if (take) begin
            head <= head + LW'(1);
        end
    end

    assign head_byte = lane[head];
    assign last      = (head == LW'(LANES - 1));

    // R3: after a refill the presented byte is the lane picked by the skip count
    a_r3_lane_pick: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (head_byte == $past(fill_data[{fill_skip, 3'b000} +: BYTE_W])));
endmodule

// File: rtl/bpf_target_map.sv
module bpf_target_map #(
    parameter int BASE_W = 4,
    parameter int OPC_W  = 8,
    localparam int TGT_W = BASE_W + OPC_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [OPC_W-1:0]  opcode,
    output logic [TGT_W-1:0]  target
);
    assign target = {base, opcode};
endmodule

// File: rtl/bytecode_prefetch.sv
module bytecode_prefetch
    import bpf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 8,
    parameter int BASE_W = 4,
    localparam int LW     = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W,
    localparam int TGT_W  = BASE_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_value,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic              disp_req,
    output logic              disp_valid,
    output logic [BYTE_W-1:0] disp_byte,
    output logic [TGT_W-1:0]  disp_target,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic          fill, take, last;
    logic [LW-1:0] fill_skip;

    assign take = disp_req && disp_valid;

    bpf_fetch_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .mem_rvalid (mem_rvalid),
        .take       (take),
        .last       (last),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill       (fill),
        .fill_skip  (fill_skip),
        .disp_valid (disp_valid)
    );

    bpf_byte_store #(.LANES(LANES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (fill),
        .fill_data (mem_rdata),
        .fill_skip (fill_skip),
        .take      (take),
        .head_byte (disp_byte),
        .last      (last)
    );

    bpf_target_map #(.BASE_W(BASE_W), .OPC_W(BYTE_W)) u_map (
        .base   (tbl_base),
        .opcode (disp_byte),
        .target (disp_target)
    );

    // R9: a jump cycle never offers a byte
    a_r9_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !disp_valid);
endmodule

// File: tb/sim_bytecode_prefetch.sv
`timescale 1ns/1ps
module sim_bytecode_prefetch;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_value = '0;
    logic [3:0]  tbl_base = 4'd3;
    logic        disp_req = 1'b0;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic [11:0] disp_target;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bytecode_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
        .tbl_base(tbl_base), .disp_req(disp_req), .disp_valid(disp_valid),
        .disp_byte(disp_byte), .disp_target(disp_target), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] fb(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
    endfunction

    function automatic logic [63:0] word_at(input logic [15:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[i*8 +: 8] = fb(a + 16'(i));
        return w;
    endfunction

    // memory model: fixed latency, one outstanding read
    logic        pend;
    int          cnt;
    logic [15:0] paddr, last_req_addr, first_req_addr;
    bit          first_seen;
    int          overlap;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0; mem_rdata <= '0; pend <= 1'b0; cnt <= 0;
            paddr <= '0; last_req_addr <= '0; first_req_addr <= '0;
            first_seen <= 1'b0; overlap <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) begin
                if (pend || mem_addr[2:0] != 3'd0) overlap <= overlap + 1;
                pend <= 1'b1; cnt <= LAT; paddr <= mem_addr;
                last_req_addr <= mem_addr;
                if (!first_seen) begin first_req_addr <= mem_addr; first_seen <= 1'b1; end
            end else if (pend) begin
                if (cnt == 1) begin
                    mem_rvalid <= 1'b1; mem_rdata <= word_at(paddr); pend <= 1'b0;
                end
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one dispatch: raise request, wait for valid, check byte and target, consume
    task automatic disp_expect(input logic [15:0] pc, input string tag, output int waited);
        @(negedge clk);
        disp_req = 1'b1;
        #1;
        waited = 0;
        while (!disp_valid && waited < 50) begin
            @(negedge clk); #1; waited++;
        end
        chk(disp_valid, "R4 valid", 32'(disp_valid), 32'd1);
        chk(disp_byte == fb(pc), tag, 32'(disp_byte), 32'(fb(pc)));
        chk(disp_target == {tbl_base, fb(pc)}, "R5 target", 32'(disp_target), 32'({tbl_base, fb(pc)}));
        @(posedge clk); #1;
        disp_req = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] pc);
        @(negedge clk);
        pc_load = 1'b1; pc_value = pc;
        @(posedge clk); #1;
        pc_load = 1'b0;
    endtask

    // op: 0 = dispatch N bytes, 1 = jump to address, 2 = set table base
    localparam logic [21:0] VEC [10] = '{
        {2'd0, 4'h0, 16'd10},
        {2'd1, 4'h0, 16'h0123},
        {2'd0, 4'h0, 16'd7},
        {2'd2, 4'hA, 16'd0},
        {2'd0, 4'h0, 16'd3},
        {2'd1, 4'h0, 16'h0207},
        {2'd0, 4'h0, 16'd2},
        {2'd2, 4'h5, 16'd0},
        {2'd1, 4'h0, 16'h0400},
        {2'd0, 4'h0, 16'd9}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] pc;
        bit after_load;
        int w;

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!disp_valid, "R1 reset valid", 32'(disp_valid), 32'd0);
        end
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(!disp_valid, "R1 empty after reset", 32'(disp_valid), 32'd0);
        disp_expect(16'h0000, "R1 first byte", w);
        chk(w > 0, "R1 stall before first word", 32'(w), 32'd1);
        chk(first_req_addr == 16'h0000, "R1 first address", 32'(first_req_addr), 32'd0);
        pc = 16'h0001;
        after_load = 1'b0;

        // vector walk: R3 ordering, R4 consumption, R8 jumps
        for (int v = 0; v < 10; v++) begin
            case (VEC[v][21:20])
                2'd0: for (int n = 0; n < int'(VEC[v][15:0]); n++) begin
                    disp_expect(pc, after_load ? "R8 byte after load" : "R3 byte order", w);
                    after_load = 1'b0;
                    pc = pc + 16'd1;
                end
                2'd1: begin
                    do_load(VEC[v][15:0]);
                    pc = VEC[v][15:0];
                    after_load = 1'b1;
                end
                default: begin
                    @(negedge clk); tbl_base = VEC[v][19:16];
                end
            endcase
        end

        // R6: finish current word, stay idle, refill must happen alone
        while (pc[2:0] != 3'd0) begin
            disp_expect(pc, "R4 byte", w);
            pc = pc + 16'd1;
        end
        repeat (LAT + 6) @(posedge clk);
        #1;
        chk(last_req_addr == 16'h0410, "R6 next word address", 32'(last_req_addr), 32'h0410);
        chk(disp_valid, "R6 refilled without request", 32'(disp_valid), 32'd1);
        for (int n = 0; n < 8; n++) begin
            disp_expect(pc, "R6 byte", w);
            if (n == 0) chk(w == 0, "R6 no stall", 32'(w), 32'd0);
            pc = pc + 16'd1;
        end

        // R7: request immediately after lane 7 is gone
        disp_expect(pc, "R7 byte after stall", w);
        chk(w >= LAT, "R7 stall length", 32'(w), 32'(LAT));
        pc = pc + 16'd1;

        // R9: jump and dispatch in the same cycle
        @(negedge clk);
        pc_load = 1'b1; pc_value = 16'h0300; disp_req = 1'b1;
        #1;
        chk(!disp_valid, "R9 valid low on load", 32'(disp_valid), 32'd0);
        @(posedge clk); #1;
        pc_load = 1'b0; disp_req = 1'b0;
        disp_expect(16'h0300, "R9 no byte consumed", w);

        // R10: jump while a read is in flight
        do_load(16'h0500);
        @(posedge clk);
        do_load(16'h0611);
        disp_expect(16'h0611, "R10 stale word dropped", w);
        chk(last_req_addr == 16'h0610, "R10 new request address", 32'(last_req_addr), 32'h0610);
        disp_expect(16'h0612, "R10 following byte", w);

        chk(overlap == 0, "R2 single outstanding aligned", 32'(overlap), 32'd0);

        finish_run();
    end
endmodule